// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two signed two's-complement operands of width N and returns their 2N-bit signed product. It uses radix-2 Booth recoding: at every step it looks at the lowest bit of the multiplier register together with one extra bit held to its right. From that pair it chooses to add the multiplicand, subtract it, or do nothing. The combined accumulator, multiplier register and extra bit then shift right by one place, with the sign kept.

A single-cycle `start` pulse loads both operands while the block is idle. The block then runs exactly N steps, one per clock, under a counter that counts down. When the result is ready, `done` goes high for one cycle. The product stays on its output until the next accepted start. A start that arrives during a multiplication is ignored.

Top module: `booth_mul`

## Requirements
- R1: A synchronous active-high `rst` forces `done` to 0 and `product` to 0 from the next clock edge, abandons any multiplication in progress, and returns the block to idle so that no `done` follows.
- R2: A `start` sampled high while idle loads the operands. `done` rises exactly N clock edges after that loading edge.
- R3: `done` is high for exactly one cycle per accepted start and never on its own.
- R4: When `done` is high, `product` equals the signed product of the loaded `multiplicand` and `multiplier`, read as N-bit two's-complement values, as a 2N-bit two's-complement value (for example -5 times -7 gives +35).
- R5: `start` and operand changes while a multiplication runs have no effect on the result or its timing.
- R6: While idle with `start` low, `product` holds its value, even when the operand inputs change.
- R7: A `start` in the same cycle as `done` is accepted, so operations can run back to back with no gap cycle.
- R8: The most negative multiplicand times the most negative multiplier gives the correct positive product (with N=4, -8 times -8 gives +64).
- R9: Latency does not depend on the data. Alternating multiplier bit patterns, which need the most add and subtract steps, finish in the same cycle as all-zero or all-one patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a multiplication when idle |
| multiplicand | input | N | Signed multiplicand |
| multiplier | input | N | Signed multiplier |
| product | output | 2N | Signed product, valid when done |
| done | output | 1 | One-cycle pulse when the product is valid |

## Verification
A wrong choice between add, subtract and no-op, or a shift that loses the sign, changes the bits of `product` that are visible at the cycle `done` rises, N cycles after loading. An off-by-one in the sequence counter moves `done` by a cycle and also leaves the product shifted by a factor of two, so it is visible on the same pulse. A control state that restarts on a busy `start`, or fails to return to idle, shows as a `done` with no matching request, a missing `done`, or a `product` that drifts while idle.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;   // capture operands, clear accumulator and extra bit
    logic step;   // one recode-and-shift iteration
  } boothCtrl_t;

endpackage

// File: rtl/booth_mul_ctrl.sv
module booth_mul_ctrl
  import booth_mul_pkg::*;
#(
  parameter int N = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  output boothCtrl_t ctrl,
  output logic       busy,
  output logic       done
);

  localparam int CW = $clog2(N + 1);

  logic [CW-1:0] seqCnt;

  always_comb begin
    ctrl.load = start && !busy;
    ctrl.step = busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      seqCnt <= '0;
    end else begin
      done <= 1'b0;
      if (ctrl.load) begin
        busy   <= 1'b1;
        seqCnt <= CW'(N);
      end else if (ctrl.step) begin
        seqCnt <= seqCnt - 1'b1;
        if (seqCnt == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/booth_mul_dp.sv
module booth_mul_dp
  import booth_mul_pkg::*;
#(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  boothCtrl_t     ctrl,
  input  logic [N-1:0]   multiplicand,
  input  logic [N-1:0]   multiplier,
  output logic [2*N-1:0] product
);

  // one guard bit keeps the most negative multiplicand representable
  localparam int AW = N + 1;

  logic [AW-1:0] accReg;
  logic [AW-1:0] mcandReg;
  logic [N-1:0]  mplrReg;
  logic          extraBit;
  logic [1:0]    pairBits;
  logic [AW-1:0] accNext;

  always_comb begin
    pairBits = {mplrReg[0], extraBit};
    unique case (pairBits)
      2'b10:   accNext = accReg - mcandReg;  // entering a run of ones
      2'b01:   accNext = accReg + mcandReg;  // leaving a run of ones
      default: accNext = accReg;             // inside a run
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      accReg   <= '0;
      mcandReg <= '0;
      mplrReg  <= '0;
      extraBit <= 1'b0;
    end else if (ctrl.load) begin
      accReg   <= '0;
      mcandReg <= {multiplicand[N-1], multiplicand};
      mplrReg  <= multiplier;
      extraBit <= 1'b0;
    end else if (ctrl.step) begin
      // arithmetic shift of {acc, mplr, extra}
      accReg   <= {accNext[AW-1], accNext[AW-1:1]};
      mplrReg  <= {accNext[0], mplrReg[N-1:1]};
      extraBit <= mplrReg[0];
    end
  end

  assign product = {accReg[N-1:0], mplrReg};

endmodule

// File: rtl/booth_mul.sv
module booth_mul
  import booth_mul_pkg::*;
#(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [N-1:0]   multiplicand,
  input  logic [N-1:0]   multiplier,
  output logic [2*N-1:0] product,
  output logic           done
);

  boothCtrl_t ctrl;
  logic       busy;

  booth_mul_ctrl #(.N(N)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .ctrl  (ctrl),
    .busy  (busy),
    .done  (done)
  );

  booth_mul_dp #(.N(N)) u_dp (
    .clk          (clk),
    .rst          (rst),
    .ctrl         (ctrl),
    .multiplicand (multiplicand),
    .multiplier   (multiplier),
    .product      (product)
  );

endmodule

// File: rtl/booth_mul_checker.sv
module booth_mul_checker #(
  parameter int N = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic [N-1:0]   multiplicand,
  input logic [N-1:0]   multiplier,
  input logic [2*N-1:0] product,
  input logic           done,
  input logic           busy
);

  logic [N-1:0]   capA;
  logic [N-1:0]   capB;
  logic [2*N-1:0] refProd;
  int             lat;

  always_ff @(posedge clk) begin
    if (rst) begin
      capA <= '0;
      capB <= '0;
      lat  <= 0;
    end else if (start && !busy) begin
      capA <= multiplicand;
      capB <= multiplier;
      lat  <= 0;
    end else if (busy) begin
      lat <= lat + 1;
    end
  end

  always_comb
    refProd = $signed({{N{capA[N-1]}}, capA}) * $signed({{N{capB[N-1]}}, capB});

  // R1
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (!done && product == '0));

  // R3
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R2, R5, R9: done lands N edges after the loading edge
  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> (lat == N));

  // R4, R8
  assert_product_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> (product == refProd));

  // R6
  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(product));

endmodule

bind booth_mul booth_mul_checker #(.N(N)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .start        (start),
  .multiplicand (multiplicand),
  .multiplier   (multiplier),
  .product      (product),
  .done         (done),
  .busy         (busy)
);

// File: tb/booth_mul_test.sv
module booth_mul_test;

  localparam int N = 4;
  localparam int WD_LIMIT = 20000;

  typedef struct {
    logic [2*N-1:0] prod;
    int             cyc;
    string          tag;
  } expItem_t;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic [N-1:0]   multiplicand = '0;
  logic [N-1:0]   multiplier = '0;
  logic [2*N-1:0] product;
  logic           done;

  int       checks = 0;
  int       errors = 0;
  int       cyc = 0;
  bit       finished = 1'b0;
  expItem_t sbQ[$];

  booth_mul #(.N(N)) uut (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .multiplicand (multiplicand),
    .multiplier   (multiplier),
    .product      (product),
    .done         (done)
  );

  always #10 clk = ~clk;  // 50 MHz

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [2*N-1:0] expProd(input logic [N-1:0] a, input logic [N-1:0] b);
    int sa;
    int sb;
    int p;
    sa = $signed(a);
    sb = $signed(b);
    p  = sa * sb;
    return p[2*N-1:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // monitor: compare each done pulse with the oldest expected item
  initial begin
    logic prevDone;
    prevDone = 1'b0;
    forever begin
      @(negedge clk);
      if (!rst && done) begin
        check("R3 single-cycle done", {31'd0, prevDone}, 32'd0);
        if (sbQ.size() == 0) begin
          check("R3 done without request", 32'd1, 32'd0);
        end else begin
          expItem_t e;
          e = sbQ.pop_front();
          check({e.tag, " product"}, 32'(product), 32'(e.prod));
          check({e.tag, " R2/R9 latency"}, 32'(cyc), 32'(e.cyc));
        end
      end
      prevDone = done;
    end
  end

  // driver: call at a negedge; returns at the negedge where done is seen
  task automatic issue(input logic [N-1:0] a, input logic [N-1:0] b,
                       input bit noisy, input string tag);
    expItem_t e;
    multiplicand = a;
    multiplier   = b;
    start        = 1'b1;
    e.prod = expProd(a, b);
    e.cyc  = cyc + 1 + N;
    e.tag  = tag;
    sbQ.push_back(e);
    @(negedge clk);
    if (noisy) begin
      multiplicand = ~a;
      multiplier   = b + 1'b1;
      for (int i = 0; i < N - 2; i++) @(negedge clk);
    end
    start = 1'b0;
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WD_LIMIT);
    summary();
  end

  initial begin
    logic [2*N-1:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 done after reset", {31'd0, done}, 32'd0);
    check("R1 product after reset", 32'(product), 32'd0);

    issue(4'(-5), 4'(-7), 1'b0, "R4 -5*-7");
    issue(4'(-8), 4'(-8), 1'b0, "R8 -8*-8");
    issue(4'(7), 4'(-8), 1'b0, "R4 7*-8");
    issue(4'(-8), 4'(7), 1'b0, "R8 -8*7");
    issue(4'b0101, 4'b1010, 1'b0, "R9 alternating");
    issue(4'(3), 4'b0000, 1'b0, "R9 zero run");
    issue(4'(3), 4'b1111, 1'b0, "R9 ones run");
    issue(4'(6), 4'(-3), 1'b1, "R5 busy start ignored");
    issue(4'(-1), 4'(5), 1'b1, "R5 busy start ignored");

    // R7: every pair, each started in the cycle its predecessor is done
    for (int i = 0; i < (1 << N); i++)
      for (int j = 0; j < (1 << N); j++)
        issue(N'(i), N'(j), 1'b0, "R7 back-to-back R4");

    // R6: idle hold with operands changing
    held = product;
    for (int k = 0; k < 5; k++) begin
      multiplicand = N'(k + 1);
      multiplier   = N'(k * 3);
      @(negedge clk);
      check("R6 idle hold", 32'(product), 32'(held));
    end
    check("R6 no stray done", {31'd0, done}, 32'd0);

    // R1: reset in the middle of an operation
    multiplicand = 4'(5);
    multiplier   = 4'(5);
    start        = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-op reset done", {31'd0, done}, 32'd0);
    check("R1 mid-op reset product", 32'(product), 32'd0);
    rst = 1'b0;
    repeat (N + 3) @(negedge clk);
    check("R1 no done after reset", {31'd0, done}, 32'd0);
    check("R1 scoreboard drained", 32'(sbQ.size()), 32'd0);

    summary();
  end

endmodule